// File: doc/BRIEF.md
# Asynchronous SRAM Access Controller

This block sits between a clocked host and an asynchronous static RAM with a 16-bit data bus split into two byte lanes. The host hands over one access at a time on a valid/ready interface. Each request carries a word address, a read/write flag, write data and an active-high byte mask. The controller plays out the strobe sequence the memory needs: chip enables, write enable, output enable, byte enables, the address, and the write data with its drive enable. A read ends with a single-cycle response pulse that carries the sampled word.

Every analog interval is a parameter in nanoseconds for one of two speed grades. The controller converts each interval to whole clock cycles, rounding up. It then derives how long each phase lasts: the write-enable pulse, the read wait, and the recovery gap after each access. The secondary chip enable stays high. The primary chip enable is low only while an access is running. Output enable is never low during a write, and the data drivers only switch on once the bus has had time to float after a read.

Top module: `asram_ctl`

## Requirements
- R1: After reset, req_ready is 1, mem_cs_n, mem_we_n and mem_oe_n are 1, mem_cs_hi is 1, mem_lane_n is all ones and mem_dq_oe is 0.
- R2: A request is accepted only when req_ready is 1, and req_ready is 1 only in the idle state. In the cycle after an acceptance, req_ready is 0.
- R3: While mem_cs_n stays low, mem_addr does not change. This also holds across the rising edge of mem_we_n. The address is held for at least the address-to-write-end time before mem_we_n rises.
- R4: mem_oe_n is 1 whenever mem_we_n is 0 or mem_dq_oe is 1.
- R5: Each low pulse on mem_we_n lasts at least ceil(write-pulse time / clock period) cycles.
- R6: mem_dq_out is driven (mem_dq_oe = 1) for at least ceil(data-setup time / clock period) cycles before mem_we_n rises. It does not change while mem_we_n is low, and it stays driven in the cycle after the rise.
- R7: Read data is sampled at the first edge that comes at least ceil(address-access time) cycles after the address is applied and at least ceil(output-enable access time) cycles after mem_oe_n falls, with a one-cycle minimum in each phase. rsp_valid is then high for exactly one cycle. With a one-cycle setup phase, rsp_valid is first seen max(AA, OE+1, 3)+1 negative edges after the accepting edge.
- R8: During an access, mem_lane_n[i] is the inverse of req_mask[i]: bit 0 is the low byte (data bits 7:0) and bit 1 is the high byte (data bits 15:8). A write touches only the enabled lanes. A mask of 00 leaves memory unchanged. A read returns 0 in every lane whose mask bit is 0.
- R9: mem_dq_oe rises no sooner than ceil(float time / clock period) cycles after mem_oe_n last went high.
- R10: Two consecutive falling edges of mem_cs_n are at least ceil(cycle time / clock period) cycles apart.
- R11: mem_cs_n is high whenever req_ready is 1, so the primary enable is low only while an access is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller idle, request can be taken |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | DATA_W | Write data |
| req_mask | input | DATA_W/8 | Active-high byte-lane mask |
| rsp_valid | output | 1 | One-cycle read response strobe |
| rsp_rdata | output | DATA_W | Read data, unselected lanes zero |
| mem_addr | output | ADDR_W | Memory address |
| mem_cs_n | output | 1 | Primary chip enable, active low |
| mem_cs_hi | output | 1 | Secondary chip select, held high |
| mem_we_n | output | 1 | Write enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_lane_n | output | DATA_W/8 | Byte-lane enables, active low |
| mem_dq_out | output | DATA_W | Data toward the memory |
| mem_dq_oe | output | 1 | Drive enable for mem_dq_out |
| mem_dq_in | input | DATA_W | Data from the memory |

## Verification
On every cycle, the assertions check the invariants of the strobe sequence. These are: the address holds while the chip enable is low, output enable stays off during writes and while the controller drives the bus, the write pulse and the access cycle meet their minimum lengths, and the drivers wait for the bus to float. Only the bench's scenarios can show that data actually lands in the right lanes and comes back. That evidence comes from a timing-aware memory model in the bench: it returns garbage before the access time has elapsed, so read results, the response latency, and the effect of masks 01, 10 and 00 are compared against a shadow copy.

// File: rtl/asram_pkg.sv
package asram_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_RD_SETUP,
      ST_RD_WAIT,
      ST_RD_CAPTURE,
      ST_WR_SETUP,
      ST_WR_PULSE,
      ST_WR_HOLD,
      ST_TURN
   } asram_state_t;

   // whole clock cycles covering an interval, rounded up
   function automatic int ns_to_cyc(input int ns, input int clk_ns);
      return (ns + clk_ns - 1) / clk_ns;
   endfunction

   function automatic int max3(input int a, input int b, input int c);
      int m;
      m = (a > b) ? a : b;
      return (m > c) ? m : c;
   endfunction

endpackage

// File: rtl/asram_timer.sv
module asram_timer #(
   parameter int CNT_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic             zero
);

   logic [CNT_W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt <= '0;
      else if (load)
         cnt <= load_val;
      else if (cnt != '0)
         cnt <= cnt - 1'b1;
   end

   assign zero = (cnt == '0);

   // R5: a running phase counts down by one each cycle, so phase lengths hold
   a_r5_countdown: assert property (@(posedge clk) disable iff (!rst_n)
      (!load && !zero) |=> (cnt == $past(cnt) - 1'b1));

endmodule

// File: rtl/asram_lane.sv
module asram_lane #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         latch,
   input  logic         cap,
   input  logic         en,
   input  logic [W-1:0] wr_in,
   input  logic [W-1:0] din,
   output logic [W-1:0] dout,
   output logic [W-1:0] rdata
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         dout <= '0;
      else if (latch)
         dout <= wr_in;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         rdata <= '0;
      else if (cap)
         rdata <= en ? din : '0;
   end

   // R8: a lane outside the mask reads back as zero
   a_r8_lane_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (cap && !en) |=> (rdata == '0));

endmodule

// File: rtl/asram_fsm.sv
module asram_fsm
   import asram_pkg::*;
#(
   parameter int CNT_W = 4,
   parameter int WPC   = 4,
   parameter int RDW   = 4,
   parameter int TA_RD = 2,
   parameter int TA_WR = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             is_write,
   input  logic             t_zero,
   output asram_state_t     state,
   output logic             load,
   output logic [CNT_W-1:0] load_val
);

   localparam logic [CNT_W-1:0] LD_WP = CNT_W'(WPC - 1);
   localparam logic [CNT_W-1:0] LD_RD = CNT_W'(RDW - 1);
   localparam logic [CNT_W-1:0] LD_TR = CNT_W'(TA_RD - 1);
   localparam logic [CNT_W-1:0] LD_TW = CNT_W'(TA_WR - 1);

   asram_state_t nxt;

   always_comb begin
      nxt      = state;
      load     = 1'b0;
      load_val = '0;
      unique case (state)
         ST_IDLE: begin
            if (start) begin
               nxt  = is_write ? ST_WR_SETUP : ST_RD_SETUP;
               load = 1'b1;
            end
         end
         ST_RD_SETUP: begin
            nxt      = ST_RD_WAIT;
            load     = 1'b1;
            load_val = LD_RD;
         end
         ST_RD_WAIT: begin
            if (t_zero) begin
               nxt  = ST_RD_CAPTURE;
               load = 1'b1;
            end
         end
         ST_RD_CAPTURE: begin
            nxt      = ST_TURN;
            load     = 1'b1;
            load_val = LD_TR;
         end
         ST_WR_SETUP: begin
            nxt      = ST_WR_PULSE;
            load     = 1'b1;
            load_val = LD_WP;
         end
         ST_WR_PULSE: begin
            if (t_zero) begin
               nxt  = ST_WR_HOLD;
               load = 1'b1;
            end
         end
         ST_WR_HOLD: begin
            nxt      = ST_TURN;
            load     = 1'b1;
            load_val = LD_TW;
         end
         ST_TURN: begin
            if (t_zero) nxt = ST_IDLE;
         end
         default: nxt = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         state <= ST_IDLE;
      else
         state <= nxt;
   end

   // R2: an accepted request always leaves idle on the next cycle
   a_r2_leave_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_IDLE && start) |=> (state != ST_IDLE));

   // R7: capture lasts exactly one cycle and follows the read wait
   a_r7_capture_once: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_RD_CAPTURE) |-> ($past(state) == ST_RD_WAIT));

endmodule

// File: rtl/asram_ctl.sv
module asram_ctl
   import asram_pkg::*;
#(
   parameter int ADDR_W     = 19,
   parameter int DATA_W     = 16,
   parameter int CLK_NS     = 10,
   parameter bit SLOW_GRADE = 1'b0
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   req_valid,
   output logic                   req_ready,
   input  logic                   req_write,
   input  logic [ADDR_W-1:0]      req_addr,
   input  logic [DATA_W-1:0]      req_wdata,
   input  logic [DATA_W/8-1:0]    req_mask,
   output logic                   rsp_valid,
   output logic [DATA_W-1:0]      rsp_rdata,
   output logic [ADDR_W-1:0]      mem_addr,
   output logic                   mem_cs_n,
   output logic                   mem_cs_hi,
   output logic                   mem_we_n,
   output logic                   mem_oe_n,
   output logic [DATA_W/8-1:0]    mem_lane_n,
   output logic [DATA_W-1:0]      mem_dq_out,
   output logic                   mem_dq_oe,
   input  logic [DATA_W-1:0]      mem_dq_in
);

   localparam int LANES = DATA_W / 8;

   // grade-dependent intervals in ns
   localparam int T_WP = SLOW_GRADE ? 50 : 40;
   localparam int T_DS = SLOW_GRADE ? 30 : 25;
   localparam int T_AW = SLOW_GRADE ? 60 : 45;
   localparam int T_AA = SLOW_GRADE ? 70 : 55;
   localparam int T_OE = SLOW_GRADE ? 35 : 25;
   localparam int T_RC = SLOW_GRADE ? 70 : 55;
   localparam int T_HZ = SLOW_GRADE ? 25 : 20;

   localparam int WP_C = ns_to_cyc(T_WP, CLK_NS);
   localparam int DS_C = ns_to_cyc(T_DS, CLK_NS);
   localparam int AW_C = ns_to_cyc(T_AW, CLK_NS);
   localparam int AA_C = ns_to_cyc(T_AA, CLK_NS);
   localparam int OE_C = ns_to_cyc(T_OE, CLK_NS);
   localparam int RC_C = ns_to_cyc(T_RC, CLK_NS);
   localparam int HZ_C = ns_to_cyc(T_HZ, CLK_NS);

   // phase lengths: one setup cycle precedes the pulse / wait
   localparam int WPC   = max3(WP_C, DS_C - 1, AW_C - 1);
   localparam int RDW   = max3(AA_C - 2, OE_C - 1, 1);
   localparam int TA_RD = max3(1, HZ_C, RC_C - (2 + RDW));
   localparam int TA_WR = max3(1, RC_C - (2 + WPC), 0);
   localparam int MAXC  = max3(WPC, RDW, max3(TA_RD, TA_WR, 1));
   localparam int CNT_W = $clog2(MAXC + 1);
   localparam int MON_W = $clog2(max3(WPC, RC_C, HZ_C) + 2);

   generate
      if (DATA_W % 8 != 0 || DATA_W < 8) begin : g_bad_width
         $error("asram_ctl: DATA_W must be a nonzero multiple of 8");
      end
      if (ADDR_W < 1) begin : g_bad_addr
         $error("asram_ctl: ADDR_W must be positive");
      end
      if (CLK_NS < 1) begin : g_bad_clk
         $error("asram_ctl: CLK_NS must be positive");
      end
   endgenerate

   asram_state_t        state;
   logic                start;
   logic                t_load;
   logic                t_zero;
   logic [CNT_W-1:0]    t_val;
   logic [ADDR_W-1:0]   addr_q;
   logic [LANES-1:0]    mask_q;
   logic                active;
   logic                cap;

   assign req_ready = (state == ST_IDLE);
   assign start     = req_valid && req_ready;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q <= '0;
         mask_q <= '0;
      end else if (start) begin
         addr_q <= req_addr;
         mask_q <= req_mask;
      end
   end

   asram_fsm #(
      .CNT_W (CNT_W),
      .WPC   (WPC),
      .RDW   (RDW),
      .TA_RD (TA_RD),
      .TA_WR (TA_WR)
   ) u_fsm (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (start),
      .is_write (req_write),
      .t_zero   (t_zero),
      .state    (state),
      .load     (t_load),
      .load_val (t_val)
   );

   asram_timer #(.CNT_W(CNT_W)) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (t_load),
      .load_val (t_val),
      .zero     (t_zero)
   );

   assign active = (state != ST_IDLE) && (state != ST_TURN);
   assign cap    = (state == ST_RD_CAPTURE);

   assign mem_addr   = addr_q;
   assign mem_cs_n   = !active;
   assign mem_cs_hi  = 1'b1;
   assign mem_we_n   = (state != ST_WR_PULSE);
   assign mem_oe_n   = !((state == ST_RD_WAIT) || (state == ST_RD_CAPTURE));
   assign mem_lane_n = active ? ~mask_q : '1;
   assign mem_dq_oe  = (state == ST_WR_SETUP) || (state == ST_WR_PULSE) ||
                       (state == ST_WR_HOLD);

   generate
      for (genvar i = 0; i < LANES; i++) begin : g_lane
         asram_lane #(.W(8)) u_lane (
            .clk   (clk),
            .rst_n (rst_n),
            .latch (start),
            .cap   (cap),
            .en    (mask_q[i]),
            .wr_in (req_wdata[i*8 +: 8]),
            .din   (mem_dq_in[i*8 +: 8]),
            .dout  (mem_dq_out[i*8 +: 8]),
            .rdata (rsp_rdata[i*8 +: 8])
         );
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         rsp_valid <= 1'b0;
      else
         rsp_valid <= cap;
   end

   // ---------------- interval monitors for the assertions ----------------
   logic [MON_W-1:0] we_run;
   logic [MON_W-1:0] oe_hi_run;
   logic [MON_W-1:0] cs_gap;
   logic             cs_n_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         we_run    <= '0;
         oe_hi_run <= MON_W'(HZ_C);
         cs_gap    <= MON_W'(RC_C);
         cs_n_q    <= 1'b1;
      end else begin
         cs_n_q <= mem_cs_n;
         we_run <= mem_we_n ? '0 : we_run + 1'b1;
         if (!mem_oe_n)
            oe_hi_run <= '0;
         else if (oe_hi_run < MON_W'(HZ_C))
            oe_hi_run <= oe_hi_run + 1'b1;
         if (cs_n_q && !mem_cs_n)
            cs_gap <= MON_W'(1);
         else if (cs_gap < MON_W'(RC_C))
            cs_gap <= cs_gap + 1'b1;
      end
   end

   a_r1_reset_quiet: assert property (@(posedge clk)
      !rst_n |-> (mem_cs_n && mem_we_n && mem_oe_n && !mem_dq_oe));

   a_r2_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> !req_ready);

   a_r3_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!mem_cs_n && $past(!mem_cs_n)) |-> $stable(mem_addr));

   a_r3_addr_past_we: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_we_n |=> $stable(mem_addr));

   a_r4_oe_off_write: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_we_n |-> mem_oe_n);

   a_r4_no_contention: assert property (@(posedge clk) disable iff (!rst_n)
      mem_dq_oe |-> mem_oe_n);

   a_r5_we_width: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mem_we_n) |-> (we_run >= MON_W'(WPC)));

   a_r6_data_steady: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_we_n |=> (mem_dq_oe && $stable(mem_dq_out)));

   a_r6_data_lead: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(mem_we_n) |-> $past(mem_dq_oe));

   a_r7_rsp_after_oe: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> ($past(!mem_oe_n) && !$past(rsp_valid)));

   a_r8_lanes_steady: assert property (@(posedge clk) disable iff (!rst_n)
      (!mem_cs_n && $past(!mem_cs_n)) |-> $stable(mem_lane_n));

   a_r9_float: assert property (@(posedge clk) disable iff (!rst_n)
      mem_dq_oe |-> (oe_hi_run >= MON_W'(HZ_C)));

   a_r10_cycle_gap: assert property (@(posedge clk) disable iff (!rst_n)
      (cs_n_q && !mem_cs_n) |-> (cs_gap >= MON_W'(RC_C)));

   a_r11_idle_deselect: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> (mem_cs_n && mem_we_n && mem_oe_n));

endmodule

// File: tb/sim_asram_ctl.sv
module sim_asram_ctl;

   localparam int AW     = 19;
   localparam int DW     = 16;
   localparam int LN     = DW / 8;
   localparam int CLK_NS = 10;

   // expected cycle counts, fast grade, rounded up
   function automatic int cyc(input int ns);
      return (ns + CLK_NS - 1) / CLK_NS;
   endfunction
   function automatic int mx(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

   localparam int E_WP = (40 + CLK_NS - 1) / CLK_NS;
   localparam int E_DS = (25 + CLK_NS - 1) / CLK_NS;
   localparam int E_AW = (45 + CLK_NS - 1) / CLK_NS;
   localparam int E_AA = (55 + CLK_NS - 1) / CLK_NS;
   localparam int E_OE = (25 + CLK_NS - 1) / CLK_NS;
   localparam int E_RC = (55 + CLK_NS - 1) / CLK_NS;
   localparam int E_HZ = (20 + CLK_NS - 1) / CLK_NS;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_valid = 1'b0;
   logic          req_ready;
   logic          req_write = 1'b0;
   logic [AW-1:0] req_addr = '0;
   logic [DW-1:0] req_wdata = '0;
   logic [LN-1:0] req_mask = '0;
   logic          rsp_valid;
   logic [DW-1:0] rsp_rdata;
   logic [AW-1:0] mem_addr;
   logic          mem_cs_n, mem_cs_hi, mem_we_n, mem_oe_n, mem_dq_oe;
   logic [LN-1:0] mem_lane_n;
   logic [DW-1:0] mem_dq_out;
   logic [DW-1:0] mem_dq_in = 16'hBAD0;

   int total = 0;
   int bad   = 0;
   bit done  = 1'b0;

   always #(CLK_NS / 2) clk = ~clk;

   asram_ctl #(.ADDR_W(AW), .DATA_W(DW), .CLK_NS(CLK_NS), .SLOW_GRADE(1'b0)) u0 (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
      .req_mask(req_mask), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
      .mem_addr(mem_addr), .mem_cs_n(mem_cs_n), .mem_cs_hi(mem_cs_hi),
      .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n), .mem_lane_n(mem_lane_n),
      .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
   );

   task automatic chk(input bit ok, input string req, input logic [31:0] act,
                      input logic [31:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
      end
   endtask

   // ---------------- memory model with access-time behaviour ----------------
   logic [DW-1:0] mem_m  [int unsigned];
   logic [DW-1:0] shadow [int unsigned];

   function automatic logic [DW-1:0] dflt(input logic [AW-1:0] a);
      return a[15:0] ^ 16'h5A3C;
   endfunction

   int            a_age = 0, o_age = 0, d_age = 0, oe_hi = 99;
   int            we_low = 0, cs_gap = 99;
   logic [AW-1:0] last_addr = '0;
   logic [DW-1:0] last_dout = '0;
   logic          prev_we = 1'b1, prev_cs = 1'b1, prev_doe = 1'b0;

   always @(negedge clk) begin
      logic [DW-1:0] w;
      if (mem_cs_n) a_age = 0;
      else if (mem_addr != last_addr) a_age = 1;
      else a_age++;
      if (mem_oe_n) o_age = 0; else o_age++;
      if (!mem_dq_oe || mem_dq_out != last_dout) d_age = mem_dq_oe ? 1 : 0;
      else d_age++;
      if (rst_n) begin
         // R3: address steady while selected
         if (!mem_cs_n && !prev_cs && mem_addr != last_addr)
            chk(1'b0, "R3 addr moved while selected", mem_addr, last_addr);
         // R4: no contention, no read strobe during write
         if ((!mem_oe_n && mem_dq_oe) || (!mem_oe_n && !mem_we_n))
            chk(1'b0, "R4 output enable during drive", mem_oe_n, 1);
         // R11: idle means deselected
         if (req_ready && !mem_cs_n)
            chk(1'b0, "R11 selected while idle", mem_cs_n, 1);
         // R9: float before drive
         if (mem_dq_oe && !prev_doe)
            chk(oe_hi >= E_HZ, "R9 float time", oe_hi, E_HZ);
         // R10: cycle gap
         if (!mem_cs_n && prev_cs) begin
            chk(cs_gap >= E_RC, "R10 cycle time", cs_gap, E_RC);
            cs_gap = 1;
         end else cs_gap++;
         // R5: write pulse width
         if (mem_we_n && !prev_we)
            chk(we_low >= E_WP, "R5 we pulse width", we_low, E_WP);
      end
      we_low = mem_we_n ? 0 : we_low + 1;
      if (mem_oe_n) oe_hi++; else oe_hi = 0;
      last_addr = mem_addr;
      last_dout = mem_dq_out;
      prev_we   = mem_we_n;
      prev_cs   = mem_cs_n;
      prev_doe  = mem_dq_oe;
      w = mem_m.exists(int'(mem_addr)) ? mem_m[int'(mem_addr)] : dflt(mem_addr);
      if (!mem_cs_n && !mem_oe_n && mem_we_n && a_age >= E_AA && o_age >= E_OE) begin
         for (int i = 0; i < LN; i++)
            mem_dq_in[i*8 +: 8] = mem_lane_n[i] ? 8'hEE : w[i*8 +: 8];
      end else mem_dq_in = 16'hBAD0;
   end

   // memory latches on the rising edge of write enable
   always @(posedge mem_we_n) begin
      logic [DW-1:0] w;
      if (rst_n && !mem_cs_n) begin
         chk(mem_dq_oe && mem_dq_out == last_dout, "R6 data held at we rise",
             mem_dq_out, last_dout);
         chk(d_age >= E_DS, "R6 data setup", d_age, E_DS);
         chk(a_age >= E_AW, "R3 address to write end", a_age, E_AW);
         w = mem_m.exists(int'(mem_addr)) ? mem_m[int'(mem_addr)] : dflt(mem_addr);
         for (int i = 0; i < LN; i++)
            if (!mem_lane_n[i]) w[i*8 +: 8] = mem_dq_out[i*8 +: 8];
         mem_m[int'(mem_addr)] = w;
      end
   end

   // ---------------- request driver ----------------
   task automatic issue(input bit wr, input logic [AW-1:0] a, input logic [DW-1:0] d,
                        input logic [LN-1:0] m);
      logic [DW-1:0] s, exp;
      int            n;
      do @(negedge clk); while (!req_ready);
      req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d; req_mask = m;
      @(posedge clk);
      @(negedge clk);
      req_valid = 1'b0;
      chk(!req_ready, "R2 ready drops after accept", req_ready, 0);
      s = shadow.exists(int'(a)) ? shadow[int'(a)] : dflt(a);
      if (wr) begin
         for (int i = 0; i < LN; i++)
            if (m[i]) s[i*8 +: 8] = d[i*8 +: 8];
         shadow[int'(a)] = s;
      end else begin
         n = 1;
         while (!rsp_valid && n < 60) begin
            @(negedge clk);
            n++;
         end
         chk(n == mx(mx(E_AA, E_OE + 1), 3) + 1, "R7 read latency", n,
             mx(mx(E_AA, E_OE + 1), 3) + 1);
         exp = '0;
         for (int i = 0; i < LN; i++)
            if (m[i]) exp[i*8 +: 8] = s[i*8 +: 8];
         chk(rsp_rdata == exp, "R8 R7 read data", rsp_rdata, exp);
         @(negedge clk);
         chk(!rsp_valid, "R7 single response pulse", rsp_valid, 0);
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog expired");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h5EED));
      repeat (3) @(negedge clk);
      // R1: reset state
      chk(req_ready && mem_cs_n && mem_we_n && mem_oe_n && mem_cs_hi &&
          mem_lane_n == '1 && !mem_dq_oe, "R1 reset outputs",
          {req_ready, mem_cs_n, mem_we_n, mem_oe_n, mem_cs_hi, mem_dq_oe}, 6'b111110);
      rst_n = 1'b1;
      @(negedge clk);
      chk(req_ready && mem_cs_n, "R1 idle after reset", {req_ready, mem_cs_n}, 2'b11);

      // directed: full word, lane writes, empty mask, lane reads
      issue(1'b1, 19'h00010, 16'hA1B2, 2'b11);
      issue(1'b0, 19'h00010, 16'h0000, 2'b11);
      issue(1'b1, 19'h00010, 16'hFFC3, 2'b01);   // low lane only
      issue(1'b0, 19'h00010, 16'h0000, 2'b11);
      issue(1'b1, 19'h00010, 16'h77FF, 2'b10);   // high lane only
      issue(1'b0, 19'h00010, 16'h0000, 2'b11);
      issue(1'b1, 19'h00010, 16'h1234, 2'b00);   // R8: no lane written
      issue(1'b0, 19'h00010, 16'h0000, 2'b11);
      issue(1'b0, 19'h00010, 16'h0000, 2'b10);   // R8: low lane returns 0
      issue(1'b0, 19'h00010, 16'h0000, 2'b01);
      issue(1'b0, 19'h00010, 16'h0000, 2'b00);
      issue(1'b0, 19'h7FFFF, 16'h0000, 2'b11);   // top address, default content
      issue(1'b1, 19'h7FFFF, 16'hC0DE, 2'b11);
      issue(1'b1, 19'h00000, 16'hBEEF, 2'b11);   // write then write
      issue(1'b0, 19'h7FFFF, 16'h0000, 2'b11);
      issue(1'b0, 19'h00000, 16'h0000, 2'b11);   // read then read

      // random mix over a small address pool
      for (int k = 0; k < 300; k++) begin
         logic [AW-1:0] a;
         a = 19'h00100 + AW'($urandom % 12);
         issue(1'($urandom % 2), a, 16'($urandom), 2'($urandom % 4));
      end

      repeat (4) @(negedge clk);
      chk(req_ready && mem_cs_n, "R11 returns to idle", {req_ready, mem_cs_n}, 2'b11);
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule